// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target (2 KiB)

This block is the target-side logic of a 2048-byte serial EEPROM on a two-wire bus. It runs on a fast system clock. Its SCL and SDA inputs are already synchronized and glitch-filtered, and it drives SDA through an open-drain output enable. The block detects START and STOP conditions and decodes three kinds of byte: the select byte, the word address and the data bytes. It supports byte write, page write of up to 16 bytes, current-address read, random read and sequential read. The storage is an internal register array. Every location starts at FFh.

Written bytes go into a one-page buffer first. They are copied into the array at the end of a self-timed write cycle, which starts at the STOP condition and lasts a fixed number of system clocks. While that cycle runs, the block does not acknowledge its select byte, so a bus master finds out that the write has finished by polling. A write-protect input blocks every write.

Top module: `ser_eeprom_target`

## Requirements
- R1: The select byte is `1010 hhh d`, sent MSB first: bits 7..4 hold the type code 1010, bits 3..1 hold the three high array address bits, and bit 0 gives the direction (1 = read). The block acknowledges only when the type code matches and no write cycle is running. Any other byte gets no acknowledge, and the block then ignores the bus until the next START.
- R2: The array address is 11 bits wide. Bits 10..8 come from select-byte bits 3..1 on every acknowledged select. Bits 7..0 come from the word-address byte of a write command.
- R3: SDA is sampled on the rising SCL edge. The output enable changes only while SCL is low, one clock after a falling SCL edge. The block pulls SDA low for the whole ninth SCL period of each byte it accepts, and it never drives SDA while the master sends data bits.
- R4: A page write stores data bytes at successive addresses. Only address bits 3..0 advance, and bits 10..4 stay fixed. Byte 17 and later wrap within the 16-byte page and replace the earlier bytes, so the last byte written to a location wins.
- R5: Write data reaches the array only after STOP, when WRITE_CYCLES clocks have elapsed. A data byte counts only once it has been acknowledged. A partial byte cut off by STOP is discarded, and the complete bytes before it are still stored.
- R6: If the write-protect input is high at any clock between the acknowledged write select and the STOP, nothing is stored and no write cycle starts. This holds whether the input is held high throughout or pulsed high for a short time.
- R7: After a STOP that ends a write carrying at least one data byte, the select byte is not acknowledged for WRITE_CYCLES clocks. It is acknowledged again once that time has passed.
- R8: A read returns the byte at the address counter and then increments all 11 bits, wrapping from 7FFh to 000h. The next byte follows each time the master acknowledges. A master not-acknowledge ends the read.
- R9: The address counter points one past the last byte accessed. A current-address read returns the byte at {select bits 3..1, counter bits 7..0}. A random read is a write command that carries only the word address, followed by a repeated START and a read select byte.
- R10: After reset every array location reads FFh and SDA is released.
- R11: A START or STOP that arrives during the select byte cancels the command without an acknowledge and without starting a write cycle. A complete select byte after that is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized, filtered bus clock |
| sda_i | input | 1 | Synchronized, filtered bus data (wired-AND line level) |
| wp_i | input | 1 | Write-protect, high blocks all writes |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The output enable is registered. It settles one clock after the falling SCL edge that ends the eighth bit of a byte (for an acknowledge) or the previous bit (for read data). The bench therefore holds SCL high for several clocks and samples the line only at the end of that high phase. Write data becomes visible WRITE_CYCLES clocks after the STOP is detected. The bench does not read the array early. It first polls the select byte until an acknowledge appears, measures the clocks that elapsed since the STOP against the configured write time, and only then compares read data with its own reference model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_SEL_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } eep_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         BYTE_W   = 8;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moving while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
  parameter int CYCLES = 2000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (launch_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  localparam int NSLOT = 1 << PAGE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [eep_pkg::BYTE_W-1:0]        wr_data_i,
  output logic [NSLOT-1:0][eep_pkg::BYTE_W-1:0] slot_data_o,
  output logic [NSLOT-1:0]                  slot_vld_o,
  output logic [ADDR_W-PAGE_W-1:0]          base_o,
  output logic                              any_vld_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_data_o[g] <= '0;
        slot_vld_o[g]  <= 1'b0;
      end else if (clear_i) begin
        slot_vld_o[g]  <= 1'b0;
      end else if (wr_i && wr_addr_i[PAGE_W-1:0] == PAGE_W'(g)) begin
        slot_data_o[g] <= wr_data_i;
        slot_vld_o[g]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_o <= '0;
    else if (wr_i) base_o <= wr_addr_i[ADDR_W-1:PAGE_W];
  end

  assign any_vld_o = |slot_vld_o;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  localparam int NSLOT = 1 << PAGE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]              base_i,
  input  logic [NSLOT-1:0][eep_pkg::BYTE_W-1:0] slot_data_i,
  input  logic [NSLOT-1:0]                      slot_vld_i,
  input  logic [ADDR_W-1:0]                     rd_addr_i,
  output logic [eep_pkg::BYTE_W-1:0]            rd_data_o
);
  logic [eep_pkg::BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '1;
    end else if (commit_i) begin
      for (int i = 0; i < NSLOT; i++)
        if (slot_vld_i[i]) mem_q[{base_i, PAGE_W'(i)}] <= slot_data_i[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ser_eeprom_target.sv
module ser_eeprom_target #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  import eep_pkg::*;

  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int NSLOT = 1 << PAGE_W;

  logic scl_rise, scl_fall, start, stop;
  eep_state_e state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              oe_q, rw_q, mack_q, cancel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] rd_data;
  logic              busy, commit, launch;
  logic              rx_state, rx_done, sel_accept, wr_phase, buf_clear, buf_wr;
  logic [NSLOT-1:0][BYTE_W-1:0] slot_data;
  logic [NSLOT-1:0]  slot_vld;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic              any_vld;

  eep_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  assign rx_state   = state_q inside {ST_SEL, ST_WADDR, ST_WDATA};
  assign rx_done    = rx_state && scl_fall && bit_cnt_q == 4'd8;
  assign sel_accept = state_q == ST_SEL && rx_done &&
                      sh_q[7:4] == DEV_TYPE && !busy;
  assign wr_phase   = state_q inside {ST_WDATA, ST_WDATA_ACK};
  assign buf_clear  = state_q == ST_WADDR_ACK && scl_fall;
  assign buf_wr     = state_q == ST_WDATA && rx_done;
  assign launch     = stop && wr_phase && any_vld && !cancel_q && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cancel_q <= 1'b0;
    else if (sel_accept) cancel_q <= wp_i;
    else if (wp_i)       cancel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      addr_q    <= '0;
    end else if (start) begin
      state_q   <= ST_SEL;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
    end else begin
      if (rx_state && scl_rise && bit_cnt_q < 4'd8) begin
        sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_SEL: if (rx_done) begin
          if (sel_accept) begin
            oe_q    <= 1'b1;
            rw_q    <= sh_q[0];
            addr_q[ADDR_W-1:BYTE_W] <= sh_q[HI_W:1];
            state_q <= ST_SEL_ACK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_SEL_ACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (rw_q) begin
            sh_q    <= rd_data;
            oe_q    <= ~rd_data[BYTE_W-1];
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_RDATA;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_WADDR;
          end
        end
        ST_WADDR: if (rx_done) begin
          addr_q[BYTE_W-1:0] <= sh_q;
          oe_q    <= 1'b1;
          state_q <= ST_WADDR_ACK;
        end
        ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
          state_q   <= ST_WDATA;
        end
        ST_WDATA: if (rx_done) begin
          addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
          oe_q    <= 1'b1;
          state_q <= ST_WDATA_ACK;
        end
        ST_RDATA: begin
          if (scl_rise) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_i;
          if (scl_fall) begin
            if (mack_q) begin
              sh_q      <= rd_data;
              oe_q      <= ~rd_data[BYTE_W-1];
              addr_q    <= addr_q + 1'b1;
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  eep_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .clear_i(buf_clear), .wr_i(buf_wr),
    .wr_addr_i(addr_q), .wr_data_i(sh_q),
    .slot_data_o(slot_data), .slot_vld_o(slot_vld), .base_o(base), .any_vld_o(any_vld)
  );

  eep_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .launch_i(launch), .busy_o(busy), .done_o(commit)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .rst_ni, .commit_i(commit), .base_i(base),
    .slot_data_i(slot_data), .slot_vld_i(slot_vld),
    .rd_addr_i(addr_q), .rd_data_o(rd_data)
  );

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               wp_i,
  input logic               sda_oe_o,
  input logic               busy,
  input logic               stop,
  input logic [3:0]         bit_cnt,
  input eep_pkg::eep_state_e st,
  input logic [ADDR_W-1:0]  addr
);
  import eep_pkg::*;

  logic in_wr;
  assign in_wr = st inside {ST_WDATA, ST_WDATA_ACK};

  // R3
  a_r3_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  // R3
  a_r3_bitcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 4'd8);

  // R7
  a_r7_no_drive_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  // R4
  a_r4_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wr && $past(in_wr)) |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  // R6
  a_r6_wp_blocks_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && wp_i) |=> !$rose(busy));
endmodule

bind ser_eeprom_target eep_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .wp_i(wp_i), .sda_oe_o(sda_oe_o),
  .busy(busy), .stop(stop), .bit_cnt(bit_cnt_q), .st(state_q), .addr(addr_q)
);

// File: tb/ser_eeprom_target_tb.sv
module ser_eeprom_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 4;
  localparam int WC = 400;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1, wp = 0;
  logic sda_oe, sda_line;
  int checks = 0, failures = 0;
  longint cyc = 0;
  bit done = 0;

  logic [7:0]  exp_mem [2048];
  logic [10:0] exp_ptr = '0;
  logic [7:0]  wbuf [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = sda_m & ~sda_oe;

  ser_eeprom_target #(.WRITE_CYCLES(WC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input bit b, output bit rd);
    sda_m = b;
    wait_clk(H);
    scl = 1;
    wait_clk(H);
    rd = sda_line;
    scl = 0;
  endtask

  task automatic bus_start();
    sda_m = 1; wait_clk(H);
    scl = 1;   wait_clk(H);
    sda_m = 0; wait_clk(H);
    scl = 0;
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_clk(H);
    scl = 1;   wait_clk(H);
    sda_m = 1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(b[i], r);
      if (r != b[i]) check(0, "R3 target drove during master bit", r, b[i]);
    end
    bus_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit r;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      d = {d[6:0], r};
    end
    bus_bit(!give_ack, r);
  endtask

  function automatic logic [7:0] sel(input logic [2:0] hi, input bit rd);
    return {4'b1010, hi, rd};
  endfunction

  // select with model update of the high address bits
  task automatic do_sel(input logic [2:0] hi, input bit rd, output bit ack);
    send_byte(sel(hi, rd), ack);
    if (ack) exp_ptr[10:8] = hi;
  endtask

  task automatic poll_ready(output longint waited);
    bit ack;
    longint t0 = cyc;
    do begin
      bus_start();
      do_sel(exp_ptr[10:8], 0, ack);
      bus_stop();
    end while (!ack && cyc - t0 < 20 * WC);
    waited = cyc - t0;
  endtask

  // mode 0: normal, 1: wp held high, 2: wp pulse during second byte
  task automatic page_write(input logic [10:0] a, input int n, input int mode);
    bit ack;
    logic [10:0] p;
    logic [7:0] tmp [16];
    logic [15:0] hit;
    longint t0, waited;
    if (mode == 1) wp = 1;
    bus_start();
    do_sel(a[10:8], 0, ack);
    check(ack, "R1 write select ack", ack, 1);
    send_byte(a[7:0], ack);
    check(ack, "R2 word address ack", ack, 1);
    exp_ptr = a;
    p = a;
    hit = '0;
    for (int i = 0; i < n; i++) begin
      if (mode == 2 && i == 1) wp = 1;
      send_byte(wbuf[i], ack);
      if (mode == 2 && i == 1) wp = 0;
      check(ack, "R3 data ack in ninth clock", ack, 1);
      tmp[p[3:0]] = wbuf[i];
      hit[p[3:0]] = 1;
      p[3:0] = p[3:0] + 1;
    end
    exp_ptr = p;
    bus_stop();
    wp = 0;
    t0 = cyc;
    if (mode == 0 && n > 0) begin
      for (int s = 0; s < 16; s++) if (hit[s]) exp_mem[{a[10:4], 4'(s)}] = tmp[s];
      bus_start();
      send_byte(sel(exp_ptr[10:8], 0), ack);
      bus_stop();
      check(!ack, "R7 select refused right after STOP", ack, 0);
    end
    poll_ready(waited);
    waited = cyc - t0;
    if (mode == 0 && n > 0)
      check(waited >= WC && waited <= WC + 300, "R7 busy window length", waited, WC);
    else
      check(waited < 200, "R6 no write cycle started", waited, 0);
  endtask

  task automatic rand_read(input logic [10:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    do_sel(a[10:8], 0, ack);
    send_byte(a[7:0], ack);
    exp_ptr = a;
    bus_start();
    do_sel(a[10:8], 1, ack);
    check(ack, "R9 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1;
    end
    bus_stop();
  endtask

  task automatic cur_read();
    bit ack;
    logic [7:0] d;
    bus_start();
    do_sel(exp_ptr[10:8], 1, ack);
    recv_byte(0, d);
    bus_stop();
    check(d == exp_mem[exp_ptr], "R9 current-address read", d, exp_mem[exp_ptr]);
    exp_ptr = exp_ptr + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack, r;
    logic [10:0] a;
    longint w;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
    wait_clk(3);
    rst_n = 1;
    wait_clk(3);
    check(sda_oe == 0, "R10 SDA released after reset", sda_oe, 0);

    rand_read(11'h3C5, 3, "R10 erased bytes read FFh");

    // R1 wrong type code
    bus_start();
    send_byte(8'hB0, ack);
    bus_stop();
    check(!ack, "R1 wrong type code refused", ack, 0);

    // R2 byte write with high bits in select
    wbuf[0] = 8'h5C;
    page_write(11'h5A3, 1, 0);
    rand_read(11'h5A3, 1, "R2 byte write readback");
    cur_read();

    // R4 overlong page write wraps
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(i * 7 + 3);
    page_write(11'h27B, 20, 0);
    rand_read(11'h270, 16, "R4 page wrap contents");
    page_write(11'h27B, 0, 0);
    cur_read();

    // random page writes and readbacks
    for (int k = 0; k < 8; k++) begin
      a = 11'($urandom);
      for (int i = 0; i < 20; i++) wbuf[i] = 8'($urandom);
      page_write(a, 1 + ($urandom % 18), 0);
      rand_read({a[10:4], 4'h0}, 16, "R4 random page readback");
      cur_read();
    end

    // R8 sequential read across top of array
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    page_write(11'h7FE, 2, 0);
    page_write(11'h000, 2, 0);
    rand_read(11'h7FD, 6, "R8 sequential wrap 7FFh to 000h");

    // R6 write protect held and pulsed
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h11 * 8'(i + 1);
    page_write(11'h140, 4, 1);
    rand_read(11'h140, 4, "R6 held protect leaves data");
    page_write(11'h150, 4, 2);
    rand_read(11'h150, 4, "R6 pulsed protect leaves data");

    // R5 partial byte discarded
    wbuf[0] = 8'h3A; wbuf[1] = 8'h4B;
    bus_start();
    do_sel(3'h6, 0, ack);
    send_byte(8'h20, ack);
    send_byte(wbuf[0], ack);
    send_byte(wbuf[1], ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, r);
    bus_stop();
    exp_mem[11'h620] = 8'h3A; exp_mem[11'h621] = 8'h4B;
    exp_ptr = 11'h622;
    poll_ready(w);
    rand_read(11'h620, 3, "R5 partial byte dropped");

    // R11 START then STOP inside select byte
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(sel(3'h1, 0)[7 - i], r);
    bus_start();
    do_sel(3'h1, 0, ack);
    bus_stop();
    check(ack, "R11 select after START cancel", ack, 1);
    bus_start();
    for (int i = 0; i < 5; i++) bus_bit(sel(3'h2, 0)[7 - i], r);
    bus_stop();
    w = cyc;
    bus_start();
    do_sel(3'h2, 0, ack);
    bus_stop();
    check(ack && cyc - w < 200, "R11 STOP cancel starts no write", ack, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule